// File: doc/BRIEF.md
# Phase Sequencer with Boot State and Timed Hold

The phase sequencer is a free-running control sequence for a larger controller. It steps through four user phases in a fixed loop. LAUNCH is the declared entry phase. COUNT is a counting phase. HOLD is a timed wait. TAIL is the last phase, and it issues an exit command. The loop only needs a clock and an asynchronous reset. Each cycle the block reports four things: the current phase code, a per-phase active vector, and per-phase one-cycle entering and exiting strobes. It also gives a result pulse that marks the end of the counting phase.

Phase codes are BOOT=0, LAUNCH=1, COUNT=2, HOLD=3 and TAIL=4, in a 3-bit code. Bit i of each flag vector belongs to code i. The transitions are:
- BOOT→LAUNCH, always.
- LAUNCH→COUNT, always.
- COUNT→HOLD, once the COUNT counter reads COUNT_LIMIT.
- HOLD→TAIL, once the hold counter reaches DELAY_CYCLES−1.
- TAIL→reset phase, which is the exit command.

With INSTANT_ENTRY=0 the machine resets into a hidden BOOT phase. LAUNCH therefore becomes active only after the first clock edge, and its entering strobe fires normally. With INSTANT_ENTRY=1 the reset phase is LAUNCH itself, so code 0 is never used. In that mode LAUNCH's entering strobe fires only when TAIL returns to it, never at reset.

Top module: `phase_sequencer`

## Requirements
- R1: While reset is asserted, and immediately on its assertion (asynchronous), state_o is 0 (BOOT) when INSTANT_ENTRY=0 and 1 (LAUNCH) when INSTANT_ENTRY=1, and active_o has the bit of that code set.
- R2: BOOT lasts exactly one cycle and is always followed by LAUNCH, so entering_o[1] is high during the BOOT cycle.
- R3: entering_o[i] is high exactly when the next phase is code i and the current phase is not i.
- R4: exiting_o[i] is high exactly when the current phase is code i and the next phase is not i.
- R5: The COUNT counter is cleared on entry, with priority over the increment. It then increments each cycle in COUNT, and COUNT is left in the cycle the counter reads COUNT_LIMIT, so COUNT lasts COUNT_LIMIT+1 cycles.
- R6: result_o is a one-cycle pulse, high exactly in the last cycle of COUNT.
- R7: HOLD lasts exactly DELAY_CYCLES cycles on every visit, because its counter restarts on each entry.
- R8: TAIL lasts one cycle and then returns to the reset phase (BOOT or LAUNCH, per R1).
- R9: With INSTANT_ENTRY=1 the loop is LAUNCH, COUNT, HOLD, TAIL and back to LAUNCH, and entering_o[1] is low in the first cycle after reset and high in each TAIL cycle.
- R10: Exactly one bit of active_o is set at all times, the bit for state_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| state_o | output | 3 | Current phase code |
| active_o | output | 5 | One-hot current-phase flags, bit i for code i |
| entering_o | output | 5 | Phase entered at the next edge |
| exiting_o | output | 5 | Phase left at the next edge |
| result_o | output | 1 | Pulse in the last cycle of COUNT |

## Verification
The bench builds two copies of the block. One uses boot mode with COUNT_LIMIT=4 and DELAY_CYCLES=4, and the other uses instant entry with COUNT_LIMIT=4 and DELAY_CYCLES=3. The short hold lengths allow two full loops within a few dozen cycles, which shows that HOLD reloads on the second visit. Running both start modes side by side compares the reset phase and the LAUNCH entry strobe at reset against the same strobe after the exit command. A reset asserted in mid-run checks the asynchronous return to the reset phase and the restart of the sequence.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
    localparam int NUM_STATES = 5;
    localparam int CODE_W     = 3;

    typedef enum logic [CODE_W-1:0] {
        ST_BOOT   = 3'd0,
        ST_LAUNCH = 3'd1,
        ST_COUNT  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_TAIL   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/phase_seq_tally.sv
// Up counter: clear wins over step.
module phase_seq_tally #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            value <= '0;
        end else if (clear) begin
            value <= '0;
        end else if (step) begin
            value <= value + W'(1);
        end
    end
endmodule

// File: rtl/phase_seq_next.sv
// Next-phase selection.
module phase_seq_next
    import phase_seq_pkg::*;
#(
    parameter bit INSTANT_ENTRY = 1'b0
) (
    input  seq_state_e state_q,
    input  logic       count_hit,
    input  logic       delay_done,
    output seq_state_e state_d
);
    localparam seq_state_e RESET_ST = INSTANT_ENTRY ? ST_LAUNCH : ST_BOOT;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_COUNT;
            ST_COUNT:  if (count_hit)  state_d = ST_HOLD;
            ST_HOLD:   if (delay_done) state_d = ST_TAIL;
            ST_TAIL:   state_d = RESET_ST;
            default:   state_d = RESET_ST;
        endcase
    end
endmodule

// File: rtl/phase_seq_flags.sv
// Per-phase active, entering and exiting flags from current/next compare.
module phase_seq_flags
    import phase_seq_pkg::*;
(
    input  logic [CODE_W-1:0]     cur,
    input  logic [CODE_W-1:0]     nxt,
    output logic [NUM_STATES-1:0] active,
    output logic [NUM_STATES-1:0] entering,
    output logic [NUM_STATES-1:0] exiting
);
    for (genvar i = 0; i < NUM_STATES; i++) begin : g_code
        localparam logic [CODE_W-1:0] CODE = CODE_W'(i);
        assign active[i]   = (cur == CODE);
        assign entering[i] = (nxt == CODE) && (cur != CODE);
        assign exiting[i]  = (cur == CODE) && (nxt != CODE);
    end
endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import phase_seq_pkg::*;
#(
    parameter bit INSTANT_ENTRY = 1'b0,
    parameter int COUNT_LIMIT   = 4,
    parameter int DELAY_CYCLES  = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [CODE_W-1:0]     state_o,
    output logic [NUM_STATES-1:0] active_o,
    output logic [NUM_STATES-1:0] entering_o,
    output logic [NUM_STATES-1:0] exiting_o,
    output logic                  result_o
);
    localparam int CW = $clog2(COUNT_LIMIT + 1);
    localparam int DW = $clog2(DELAY_CYCLES + 1);
    localparam seq_state_e RESET_ST = INSTANT_ENTRY ? ST_LAUNCH : ST_BOOT;

    seq_state_e            state_q;
    seq_state_e            state_d;
    logic [CW-1:0]         cnt_q;
    logic [DW-1:0]         dly_q;
    logic [NUM_STATES-1:0] act;
    logic [NUM_STATES-1:0] ent;
    logic [NUM_STATES-1:0] ext;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= RESET_ST;
        else     state_q <= state_d;
    end

    phase_seq_next #(.INSTANT_ENTRY(INSTANT_ENTRY)) u_next (
        .state_q   (state_q),
        .count_hit (cnt_q == CW'(COUNT_LIMIT)),
        .delay_done(dly_q == DW'(DELAY_CYCLES - 1)),
        .state_d   (state_d)
    );

    phase_seq_flags u_flags (
        .cur     (state_q),
        .nxt     (state_d),
        .active  (act),
        .entering(ent),
        .exiting (ext)
    );

    phase_seq_tally #(.W(CW)) u_count (
        .clk  (clk),
        .rst  (rst),
        .clear(ent[ST_COUNT]),
        .step (act[ST_COUNT]),
        .value(cnt_q)
    );

    phase_seq_tally #(.W(DW)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .clear(ent[ST_HOLD]),
        .step (act[ST_HOLD]),
        .value(dly_q)
    );

    always_comb begin
        state_o    = state_q;
        active_o   = act;
        entering_o = ent;
        exiting_o  = ext;
        result_o   = ext[ST_COUNT];
    end
endmodule

// File: rtl/phase_sequencer_chk.sv
module phase_sequencer_chk
    import phase_seq_pkg::*;
#(
    parameter bit INSTANT_ENTRY = 1'b0,
    parameter int COUNT_LIMIT   = 4,
    parameter int DELAY_CYCLES  = 40,
    parameter int CW            = 3,
    parameter int DW            = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CODE_W-1:0]     state_o,
    input logic [NUM_STATES-1:0] active_o,
    input logic [NUM_STATES-1:0] entering_o,
    input logic [NUM_STATES-1:0] exiting_o,
    input logic                  result_o,
    input logic [CW-1:0]         cnt_q,
    input logic [DW-1:0]         dly_q
);
    localparam logic [CODE_W-1:0] RST_CODE = INSTANT_ENTRY ? CODE_W'(1) : CODE_W'(0);

    p_boot_to_launch_r2: assert property (@(posedge clk) disable iff (rst)
        state_o == CODE_W'(0) |=> state_o == CODE_W'(1));

    p_enter_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (|entering_o) |=> active_o == $past(entering_o));

    p_enter_not_active_r3: assert property (@(posedge clk) disable iff (rst)
        (entering_o & active_o) == '0);

    p_exit_from_active_r4: assert property (@(posedge clk) disable iff (rst)
        (|exiting_o) |-> exiting_o == active_o);

    p_count_clear_r5: assert property (@(posedge clk) disable iff (rst)
        entering_o[2] |=> cnt_q == '0);

    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        active_o[2] |-> cnt_q <= CW'(COUNT_LIMIT));

    p_result_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        result_o |=> !result_o);

    p_delay_bound_r7: assert property (@(posedge clk) disable iff (rst)
        active_o[3] |-> dly_q < DW'(DELAY_CYCLES));

    p_tail_exit_r8: assert property (@(posedge clk) disable iff (rst)
        state_o == CODE_W'(4) |=> state_o == RST_CODE);

    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(active_o) == 1 && active_o[state_o]);
endmodule

bind phase_sequencer phase_sequencer_chk #(
    .INSTANT_ENTRY(INSTANT_ENTRY),
    .COUNT_LIMIT  (COUNT_LIMIT),
    .DELAY_CYCLES (DELAY_CYCLES),
    .CW           (CW),
    .DW           (DW)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .state_o   (state_o),
    .active_o  (active_o),
    .entering_o(entering_o),
    .exiting_o (exiting_o),
    .result_o  (result_o),
    .cnt_q     (cnt_q),
    .dly_q     (dly_q)
);

// File: tb/test_phase_sequencer.sv
module test_phase_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 26;
    localparam int NI = 12;

    // Boot mode, COUNT_LIMIT=4, DELAY_CYCLES=4: loop length 12
    localparam logic [2:0] VEC_B [NV] = '{
        3'd0, 3'd1, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd3, 3'd3, 3'd3, 3'd3, 3'd4, 3'd0,
        3'd1, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd3, 3'd3, 3'd3, 3'd3, 3'd4, 3'd0, 3'd1};
    // Instant mode, DELAY_CYCLES=3: loop length 10
    localparam logic [2:0] VEC_I [NI] = '{
        3'd1, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd3, 3'd3, 3'd3, 3'd4, 3'd1, 3'd2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    logic [2:0] st_b, st_i;
    logic [4:0] act_b, ent_b, ext_b, act_i, ent_i, ext_i;
    logic       res_b, res_i;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_sequencer #(.INSTANT_ENTRY(1'b0), .COUNT_LIMIT(4), .DELAY_CYCLES(4)) i_phase_sequencer (
        .clk(clk), .rst(rst), .state_o(st_b), .active_o(act_b),
        .entering_o(ent_b), .exiting_o(ext_b), .result_o(res_b));

    phase_sequencer #(.INSTANT_ENTRY(1'b1), .COUNT_LIMIT(4), .DELAY_CYCLES(3)) i_phase_sequencer_inst (
        .clk(clk), .rst(rst), .state_o(st_i), .active_o(act_i),
        .entering_o(ent_i), .exiting_o(ext_i), .result_o(res_i));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare one copy's outputs with the expected phase pair (cur, nxt).
    task automatic chk_step(input string tag, input logic [2:0] cur, input logic [2:0] nxt,
                            input logic [2:0] st, input logic [4:0] a, input logic [4:0] en,
                            input logic [4:0] ex, input logic rs);
        logic [4:0] e_en, e_ex;
        e_en = (nxt != cur) ? (5'd1 << nxt) : 5'd0;
        e_ex = (nxt != cur) ? (5'd1 << cur) : 5'd0;
        chk({tag, " R10 state"}, 32'(st), 32'(cur));
        chk({tag, " R10 active"}, 32'(a), 32'(5'd1 << cur));
        chk({tag, " R3 entering"}, 32'(en), 32'(e_en));
        chk({tag, " R4 exiting"}, 32'(ex), 32'(e_ex));
        chk({tag, " R6 result"}, 32'(rs), 32'(cur == 3'd2 && nxt != 3'd2));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset phase per mode
        chk("R1 boot-mode reset code", 32'(st_b), 32'd0);
        chk("R1 boot-mode reset active", 32'(act_b), 32'h01);
        chk("R1 instant reset code", 32'(st_i), 32'd1);
        chk("R1 instant reset active", 32'(act_i), 32'h02);
        rst = 1'b0;
        #1;
        // Table walk: R2, R5, R7 (second HOLD visit), R8, R9 via phase sequence
        for (int k = 0; k < NV - 1; k++) begin
            chk_step("boot R2 R5 R7 R8", VEC_B[k], VEC_B[k+1], st_b, act_b, ent_b, ext_b, res_b);
            if (k < NI - 1)
                chk_step("inst R9", VEC_I[k], VEC_I[k+1], st_i, act_i, ent_i, ext_i, res_i);
            @(negedge clk);
            #1;
        end
        // Directed: R2 launch strobe during the boot cycle (k=24 was BOOT)
        // Mid-run asynchronous reset, R1
        @(negedge clk);
        #2;
        rst = 1'b1;
        #1;
        chk("R1 async boot-mode code", 32'(st_b), 32'd0);
        chk("R1 async instant code", 32'(st_i), 32'd1);
        chk("R9 no LAUNCH entry at reset", 32'(ent_i[1]), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R2 entering LAUNCH in boot cycle", 32'(ent_b[1]), 32'd1);
        chk("R9 no LAUNCH entry after reset", 32'(ent_i[1]), 32'd0);
        for (int k = 0; k < 3; k++) begin
            chk_step("restart R2", VEC_B[k], VEC_B[k+1], st_b, act_b, ent_b, ext_b, res_b);
            chk_step("restart R9", VEC_I[k], VEC_I[k+1], st_i, act_i, ent_i, ext_i, res_i);
            @(negedge clk);
            #1;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule